// File: doc/BRIEF.md
# High-Speed Burst Lane Transmitter

This block drives one high-speed data lane of a source-synchronous serial link. When idle it keeps both single-ended lines high. A start pulse begins a burst. The block first steps the lines through a fixed low-power entry handshake. It then enables the differential driver and sends an eight-bit synchronisation leader. After the leader it serialises payload bytes taken from a valid/ready byte stream.

A byte flagged as last closes the burst. Straight after its final bit the lane flips to the opposite differential level and holds that level for a programmed trail time. It then releases the driver and returns to the idle line state. If the stream runs dry before a last byte arrives, the block raises a one-cycle underrun flag and starts the trail at once.

A bit clock enable sets the pace: each enabled cycle moves the lane on by one bit period, which matches one edge of a double-data-rate forwarded clock. Every dwell time is counted in these bit periods. Start is taken on the first clock edge that sees it, whatever the enable is doing. The wait from start to the first leader bit depends only on the entry settings. Several lanes with equal settings can therefore share one start wire and begin together, and each lane still finishes when its own payload ends.

Top module: `hs_lane_tx`

## Requirements
- R1: While reset is low, and in the first cycle after it, the outputs are at rest: lp_p=1, lp_n=1, hs_en=0, hs_bit=0, s_ready=0, underrun=0.
- R2: A start seen at a clock edge while idle begins entry at that edge, whether or not bit_en is high. The lines then show (lp_p,lp_n)=(1,1) for cfg_t11 bit periods, then (0,1) for cfg_t01, then (0,0) for cfg_t00, with hs_en low. A setting of zero acts as one.
- R3: After entry, hs_en rises with both lines low. The lane sends the leader bits in the time order 0,0,0,1,1,1,0,1, one per bit period.
- R4: Payload bytes follow the leader with no gap. Each byte is sent bit 0 first, for eight bit periods. s_ready is high only in a bit_en cycle that ends the leader or ends a byte not flagged last. A byte is taken when s_ready and s_valid are both high.
- R5: After the final bit of a byte flagged last, hs_bit takes the inverse of that bit. It holds it for cfg_trail bit periods (zero acts as one), with hs_en high and both lines low.
- R6: When the trail ends, hs_en falls, hs_bit returns to 0, the lines go back to (1,1), and the lane waits for a new start.
- R7: If s_valid is low when a byte is needed, underrun is high for exactly the first cycle of the trail, and the trail follows the last bit sent. With no payload byte at all, the trail level is 0.
- R8: The lane advances by one bit period only in cycles where bit_en is high; otherwise hs_bit and the line levels hold.
- R9: A start seen while a burst is in progress, including at the edge where the trail ends, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-period enable, one high cycle per bit |
| start | input | 1 | Burst start, may be shared by several lanes |
| cfg_t11 | input | CNT_W | Entry dwell with both lines high, in bit periods |
| cfg_t01 | input | CNT_W | Entry dwell with lp_p low and lp_n high |
| cfg_t00 | input | CNT_W | Entry dwell with both lines low |
| cfg_trail | input | CNT_W | Trail hold time, in bit periods |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte present |
| s_last | input | 1 | Payload byte ends the burst |
| s_ready | output | 1 | Payload byte taken this cycle if valid |
| hs_en | output | 1 | Differential driver enable |
| hs_bit | output | 1 | Differential bit level |
| lp_p | output | 1 | Positive-line low-power level |
| lp_n | output | 1 | Negative-line low-power level |
| underrun | output | 1 | One-cycle flag: payload ran dry before a last byte |

## Verification
At a byte boundary the fetch of the next byte and the move into the trail fall in the same cycle. Whether the lane reloads or flips to the trail depends only on s_valid in that one cycle. The bench provokes this by removing s_valid exactly when the byte before it ends, including right after the leader when no byte was ever offered. It runs this at several bit_en rates and judges each cycle's lines, trail level and underrun pulse against a bit-period model. A second coincidence, a start arriving at the very edge where the trail expires, is sent in one run, and the idle levels are then watched for longer than a full entry sequence.

// File: rtl/hs_lane_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the high-speed lane transmitter.
// Assumes payload units are whole 8-bit bytes.
package hs_lane_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    // Leader byte; bit i is the i-th bit on the wire (0,0,0,1,1,1,0,1).
    localparam logic [BYTE_W-1:0] LEADER_SEQ = 8'hB8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LP11  = 3'd1,
        ST_LP01  = 3'd2,
        ST_LP00  = 3'd3,
        ST_SYNC  = 3'd4,
        ST_DATA  = 3'd5,
        ST_TRAIL = 3'd6
    } lane_st_e;

    // Single-ended line levels {positive, negative} for each lane state.
    function automatic logic [1:0] lp_levels(input lane_st_e s);
        case (s)
            ST_IDLE, ST_LP11: lp_levels = 2'b11;
            ST_LP01:          lp_levels = 2'b01;
            default:          lp_levels = 2'b00;
        endcase
    endfunction

    // True while the differential driver is on.
    function automatic logic hs_active(input lane_st_e s);
        hs_active = (s == ST_SYNC) || (s == ST_DATA) || (s == ST_TRAIL);
    endfunction

endpackage

// File: rtl/hs_lane_dwell.sv
`timescale 1ns/1ps
// Bit-period dwell counter shared by the entry and trail states.
// Assumes clr is asserted whenever the owning state changes; a limit
// of zero is treated as one bit period.
module hs_lane_dwell #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_last;

    // Index of the final bit period in the current dwell.
    always_comb begin
        lim_last = (limit == '0) ? '0 : limit - 1'b1;
        expire   = tick && (cnt_q >= lim_last);
    end

    // Count enabled bit periods since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/hs_lane_ser.sv
`timescale 1ns/1ps
// Byte serialiser: one shift register carries the leader and then the
// payload, LSB first. It also captures the inverted trail level.
// Assumes load and lead_go never coincide and arrive only at byte ends.
module hs_lane_ser
    import hs_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              lead_go,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              load_last,
    input  logic              to_trail,
    output logic              tx_bit,
    output logic              trail_bit,
    output logic              byte_end,
    output logic              cur_last
);

    logic [BYTE_W-1:0]    shreg_q;
    logic [BIT_IDX_W-1:0] idx_q;
    logic                 last_q;
    logic                 trail_q;

    localparam logic [BIT_IDX_W-1:0] IDX_END = BIT_IDX_W'(BYTE_W - 1);

    // Present the current bit and flag the final bit period of a byte.
    always_comb begin
        tx_bit    = shreg_q[0];
        trail_bit = trail_q;
        cur_last  = last_q;
        byte_end  = shift && (idx_q == IDX_END);
    end

    // Load leader or payload, otherwise shift one bit per enabled period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
            last_q  <= 1'b0;
        end else if (lead_go) begin
            shreg_q <= LEADER_SEQ;
            idx_q   <= '0;
            last_q  <= 1'b0;
        end else if (load) begin
            shreg_q <= load_byte;
            idx_q   <= '0;
            last_q  <= load_last;
        end else if (shift) begin
            shreg_q <= shreg_q >> 1;
            idx_q   <= idx_q + 1'b1;
        end
    end

    // Capture the opposite of the bit on the wire when the trail begins.
    always_ff @(posedge clk) begin
        if (!rst_n)        trail_q <= 1'b0;
        else if (to_trail) trail_q <= ~shreg_q[0];
    end

    // A new byte may only replace the old one after its eighth bit.
    assert_load_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (idx_q == IDX_END));

endmodule

// File: rtl/hs_lane_ctrl.sv
`timescale 1ns/1ps
// Burst sequencer: idle, three entry states, leader, payload, trail.
// Assumes the serialiser reports byte ends and the dwell counter reports
// expiry of the programmed entry and trail times.
module hs_lane_ctrl
    import hs_lane_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             start,
    input  logic             s_valid,
    input  logic [CNT_W-1:0] cfg_t11,
    input  logic [CNT_W-1:0] cfg_t01,
    input  logic [CNT_W-1:0] cfg_t00,
    input  logic [CNT_W-1:0] cfg_trail,
    input  logic             byte_end,
    input  logic             cur_last,
    input  logic             dwell_exp,
    output lane_st_e         st,
    output logic             dwell_clr,
    output logic [CNT_W-1:0] dwell_lim,
    output logic             shift,
    output logic             lead_go,
    output logic             load,
    output logic             to_trail,
    output logic             s_ready,
    output logic             underrun
);

    lane_st_e st_q, st_nx;
    logic     dry_now;
    logic     urun_q;

    // Next-state selection, byte request and underrun detection.
    always_comb begin
        st_nx   = st_q;
        lead_go = 1'b0;
        load    = 1'b0;
        s_ready = 1'b0;
        dry_now = 1'b0;
        case (st_q)
            ST_IDLE:  if (start)     st_nx = ST_LP11;
            ST_LP11:  if (dwell_exp) st_nx = ST_LP01;
            ST_LP01:  if (dwell_exp) st_nx = ST_LP00;
            ST_LP00:  if (dwell_exp) begin
                          st_nx   = ST_SYNC;
                          lead_go = 1'b1;
                      end
            ST_SYNC, ST_DATA: if (byte_end) begin
                          if (st_q == ST_DATA && cur_last) begin
                              st_nx = ST_TRAIL;
                          end else begin
                              s_ready = 1'b1;
                              if (s_valid) begin
                                  load  = 1'b1;
                                  st_nx = ST_DATA;
                              end else begin
                                  dry_now = 1'b1;
                                  st_nx   = ST_TRAIL;
                              end
                          end
                      end
            ST_TRAIL: if (dwell_exp) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Steering for the serialiser and the dwell counter.
    always_comb begin
        shift     = bit_en && ((st_q == ST_SYNC) || (st_q == ST_DATA));
        to_trail  = (st_nx == ST_TRAIL) && (st_q != ST_TRAIL);
        dwell_clr = (st_nx != st_q) || (st_q == ST_IDLE);
        case (st_q)
            ST_LP11: dwell_lim = cfg_t11;
            ST_LP01: dwell_lim = cfg_t01;
            ST_LP00: dwell_lim = cfg_t00;
            default: dwell_lim = cfg_trail;
        endcase
        st       = st_q;
        underrun = urun_q;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // One-cycle underrun pulse, shown in the first trail cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) urun_q <= 1'b0;
        else        urun_q <= dry_now;
    end

    // Without a bit enable a busy lane must not change state.
    assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !bit_en) |=> $stable(st_q));

    // The underrun flag marks the first cycle of a trail.
    assert_underrun_opens_trail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        urun_q |-> (st_q == ST_TRAIL && $past(st_q) != ST_TRAIL));

endmodule

// File: rtl/hs_lane_tx.sv
`timescale 1ns/1ps
// High-speed burst lane transmitter: entry handshake, leader byte,
// LSB-first payload and inverted trail on one data lane.
// Assumes bit_en marks one bit period per high cycle and the settings
// are stable during a burst.
module hs_lane_tx
    import hs_lane_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              start,
    input  logic [CNT_W-1:0]  cfg_t11,
    input  logic [CNT_W-1:0]  cfg_t01,
    input  logic [CNT_W-1:0]  cfg_t00,
    input  logic [CNT_W-1:0]  cfg_trail,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    output logic              s_ready,
    output logic              hs_en,
    output logic              hs_bit,
    output logic              lp_p,
    output logic              lp_n,
    output logic              underrun
);

    lane_st_e         st;
    logic             dwell_clr, dwell_exp;
    logic [CNT_W-1:0] dwell_lim;
    logic             shift, lead_go, load, to_trail;
    logic             tx_bit, trail_bit, byte_end, cur_last;

    hs_lane_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .start     (start),
        .s_valid   (s_valid),
        .cfg_t11   (cfg_t11),
        .cfg_t01   (cfg_t01),
        .cfg_t00   (cfg_t00),
        .cfg_trail (cfg_trail),
        .byte_end  (byte_end),
        .cur_last  (cur_last),
        .dwell_exp (dwell_exp),
        .st        (st),
        .dwell_clr (dwell_clr),
        .dwell_lim (dwell_lim),
        .shift     (shift),
        .lead_go   (lead_go),
        .load      (load),
        .to_trail  (to_trail),
        .s_ready   (s_ready),
        .underrun  (underrun)
    );

    hs_lane_dwell #(.CNT_W(CNT_W)) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (dwell_clr),
        .tick   (bit_en),
        .limit  (dwell_lim),
        .expire (dwell_exp)
    );

    hs_lane_ser u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift     (shift),
        .lead_go   (lead_go),
        .load      (load),
        .load_byte (s_data),
        .load_last (s_last),
        .to_trail  (to_trail),
        .tx_bit    (tx_bit),
        .trail_bit (trail_bit),
        .byte_end  (byte_end),
        .cur_last  (cur_last)
    );

    // Line levels, driver enable and the bit on the wire.
    always_comb begin
        {lp_p, lp_n} = lp_levels(st);
        hs_en        = hs_active(st);
        if (!hs_en)              hs_bit = 1'b0;
        else if (st == ST_TRAIL) hs_bit = trail_bit;
        else                     hs_bit = tx_bit;
    end

    // Both single-ended lines must be low whenever the driver is on.
    assert_lines_low_in_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (!lp_p && !lp_n));

    // The first trail bit is the opposite of the bit before it.
    assert_trail_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRAIL && $past(st) != ST_TRAIL) |-> (hs_bit != $past(hs_bit)));

    // The wire holds its bit through cycles without a bit enable.
    assert_bit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && !bit_en) |=> $stable(hs_bit));

endmodule

// File: tb/sim_hs_lane_tx.sv
`timescale 1ns/1ps
module sim_hs_lane_tx;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n, bit_en, start, s_valid, s_last;
    logic [7:0]    s_data;
    logic [CW-1:0] c11, c01, c00, ctr;
    logic          s_ready, hs_en, hs_bit, lp_p, lp_n, underrun;

    always #2 clk = ~clk;

    hs_lane_tx #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
        .cfg_t11(c11), .cfg_t01(c01), .cfg_t00(c00), .cfg_trail(ctr),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .hs_en(hs_en), .hs_bit(hs_bit), .lp_p(lp_p), .lp_n(lp_n),
        .underrun(underrun)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] pay [0:15];
    int         lead_t [0:7] = '{0, 0, 0, 1, 1, 1, 0, 1};

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {lp_p,lp_n,hs_en,hs_bit,underrun,s_ready} got %b expected %b",
                     tag, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // One burst: a,b,c entry dwells, tr trail, nb bytes, ulast closes with
    // a last flag (else underrun), bit_en every p cycles, poke sends stray starts.
    task automatic run(input int a, input int b, input int c, input int tr,
                       input int nb, input bit ulast, input int p,
                       input int seed, input bit poke);
        int s_sync, s_trail, s_end, sp, bptr, cyc, idle_cyc, d, pos, k;
        bit fresh, take, be_edge;
        logic lastbit, bv, uv, rv, hv;
        logic [1:0] lpv;
        string tag;
        for (int i = 0; i < nb; i++) pay[i] = 8'((seed * 29 + i * 71 + 5) % 256);
        c11 = CW'(a); c01 = CW'(b); c00 = CW'(c); ctr = CW'(tr);
        s_sync  = eff(a) + eff(b) + eff(c);
        s_trail = s_sync + 8 + 8 * nb;
        s_end   = s_trail + eff(tr);
        lastbit = (nb == 0) ? 1'b1 : pay[nb-1][7];
        sp = -1; bptr = 0; cyc = 0; idle_cyc = 0; fresh = 0;
        @(negedge clk);
        start   = 1'b1;
        bit_en  = 1'b1;
        s_valid = (nb > 0);
        s_data  = (nb > 0) ? pay[0] : 8'h00;
        s_last  = ulast && (nb == 1);
        while (idle_cyc < 14) begin
            #1;
            lpv = 2'b11; hv = 0; bv = 0; uv = 0; rv = 0; tag = "R6 R9";
            if (sp >= 0 && sp < s_end) begin
                if (sp < eff(a)) begin
                    tag = "R2";
                end else if (sp < eff(a) + eff(b)) begin
                    lpv = 2'b01; tag = "R2";
                end else if (sp < s_sync) begin
                    lpv = 2'b00; tag = "R2";
                end else if (sp < s_sync + 8) begin
                    lpv = 2'b00; hv = 1; bv = lead_t[sp - s_sync] != 0; tag = "R3";
                end else if (sp < s_trail) begin
                    d = sp - s_sync - 8;
                    lpv = 2'b00; hv = 1; bv = pay[d / 8][d % 8]; tag = "R4";
                end else begin
                    lpv = 2'b00; hv = 1; bv = ~lastbit;
                    uv  = !ulast && (sp == s_trail) && fresh;
                    tag = ulast ? "R5" : "R5 R7";
                end
                if (sp >= s_sync && sp < s_trail) begin
                    pos = (sp - s_sync) % 8;
                    k   = (sp - s_sync) / 8 - 1;
                    rv  = bit_en && (pos == 7) && !(ulast && k == nb - 1);
                end
            end
            if (p > 1) tag = {tag, " R8"};
            check(tag, {lp_p, lp_n, hs_en, hs_bit, underrun, s_ready},
                  {lpv, hv, bv, uv, rv});
            take    = s_ready && s_valid;
            be_edge = bit_en;
            @(posedge clk);
            fresh = 0;
            if (sp < 0) begin sp = 0; fresh = 1; end
            else if (be_edge) begin sp++; fresh = 1; end
            if (take) bptr++;
            @(negedge clk);
            cyc++;
            start   = poke && (sp == s_sync + 3 || sp == s_end - 1);
            bit_en  = (cyc % p) == 0;
            s_valid = (bptr < nb);
            s_data  = (bptr < nb) ? pay[bptr] : 8'h00;
            s_last  = ulast && (bptr == nb - 1);
            if (sp >= s_end) idle_cyc++;
        end
    endtask

    initial begin
        rst_n = 0; bit_en = 1; start = 1; s_valid = 1; s_last = 0; s_data = 8'hA5;
        c11 = 1; c01 = 1; c00 = 1; ctr = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 check("R1 in reset", {lp_p, lp_n, hs_en, hs_bit, underrun, s_ready}, 6'b110000);
        start = 0; s_valid = 0;
        @(negedge clk);
        rst_n = 1;
        #1 check("R1 after reset", {lp_p, lp_n, hs_en, hs_bit, underrun, s_ready}, 6'b110000);
        // R2 R3 R4 R5 R6: plain bursts, full and slow bit rate
        run(2, 1, 3, 2, 3, 1, 1, 1, 0);
        run(1, 1, 1, 4, 1, 1, 2, 2, 0);
        // R2 R5: zero settings behave as one
        run(0, 0, 0, 0, 2, 1, 1, 3, 0);
        // R7: payload runs dry mid-burst, and straight after the leader
        run(1, 2, 1, 3, 2, 0, 1, 4, 0);
        run(2, 1, 1, 2, 0, 0, 3, 5, 0);
        // R9: stray starts mid-burst and at the trail's final edge
        run(3, 2, 1, 3, 4, 1, 1, 6, 1);
        // near-exhaustive sweep of bit rate, length and trail time
        for (int p = 1; p <= 3; p++)
            for (int n = 1; n <= 3; n++)
                for (int t = 0; t <= 2; t++)
                    run(1 + n % 2, 1, 2, t, n, (n + t) % 3 != 0, p, p * 9 + n * 3 + t, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog: got run still busy expected all bursts done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule